// File: doc/BRIEF.md
# Programmable 16-bit Event Timer Channel

This block is one channel of a 16-bit up-counting timer. Software reaches it through a small register bus with three registers: a count value, a target value and a mode word. The mode word picks the tick source. The choices are the system clock, a prescaled tick that fires once every `PRESCALE` clocks, or the rising edges of an external line. The mode word also decides whether the count returns to zero on the target or runs on to 0xFFFF. Finally, it decides which events raise an interrupt pulse and whether that pulse repeats or fires once.

Each channel keeps three sticky status bits in the upper part of the mode word: any event, target reached and overflow. A read of the mode word returns the current value and then clears the target and overflow bits. A write of the mode word restarts the channel. The count goes to zero, the prescaler restarts, the status bits clear and the one-shot interrupt is armed again. Interrupt routing to a system controller is done outside this block.

Top module: `tmr16_chan`

## Requirements
- R1: On each enabled tick the count goes up by one. A tick taken at 0xFFFF wraps the count to 0x0000, and that wrap is an overflow event.
- R2: With mode bit 3 set, a tick that would bring the count to the target value loads 0 instead and raises a target event. With bit 3 clear, the count takes the target value, raises the target event and keeps counting.
- R3: A target event sets mode bit 11 and an overflow sets bit 12. Either event sets bit 10. All three bits are sticky. A read of the mode register (address 1) returns the word and then clears bits 11 and 12 but not bit 10. An event on the same edge as the read takes priority and sets its bit.
- R4: Mode bit 4 enables the interrupt on a target event and bit 5 enables it on overflow. `irq_pulse` is high for exactly one cycle, in the cycle after the edge that took the event. If a target event and an overflow fall on the same tick, one pulse is issued.
- R5: With mode bit 6 clear, only the first enabled event after a mode write produces a pulse. With bit 6 set, every enabled event does. A mode write arms the interrupt again.
- R6: A mode write sets the count to 0, clears bits 10 to 12 and restarts the prescaler, and no event is taken on that edge. Written bits 10 to 15 are discarded. Bits 0 to 9 read back as written, and bits 13 to 15 always read as zero.
- R7: While mode bit 0 is set, the count holds its value and no events occur.
- R8: Mode bit 8 selects the slow tick in place of the system clock. Mode bit 9 then picks the source. When bit 9 is clear, one tick comes every `PRESCALE` clocks, counted from the last mode write. When bit 9 is set, one tick comes per rising edge of `ext_line`.
- R9: A write to address 0 loads the count, and no event is taken on that edge. A write to address 2 changes the target and leaves the count as the tick would have left it. A read of address 3 returns zero.
- R10: After reset the count, target and mode word all read zero and `irq_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 count, 1 mode, 2 target, 3 none |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe, used for the clear-on-read side effect |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| ext_line | input | 1 | External line, synchronous to `clk`; rising edges are slow ticks |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that the bus inputs and `ext_line` are synchronous to `clk` and hold steady across each rising edge. They also assume a write and a read are never aimed at the mode register on the same edge, although a write to the mode register always takes priority. The bench changes every input only at the falling edge and issues one bus operation per cycle. Before any run whose result it checks, it sets up the target, then the mode, then the count. This keeps leftover state from an earlier test from reaching a checked value. It holds `ext_line` high for two cycles per edge so that each rising edge is seen exactly once.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_TARGET = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // mode word bit positions
  localparam int MB_STOP     = 0;
  localparam int MB_ZERO_TGT = 3;
  localparam int MB_IRQ_TGT  = 4;
  localparam int MB_IRQ_OVF  = 5;
  localparam int MB_IRQ_REP  = 6;
  localparam int MB_SLOW     = 8;
  localparam int MB_LINE     = 9;
  localparam int CFG_W       = 10;

  // value the count takes on the next tick
  function automatic logic [CNT_W-1:0] next_on_tick(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] tgt,
    input logic             zero_at_tgt
  );
    logic [CNT_W-1:0] inc;
    inc = cur + 1'b1;
    if (zero_at_tgt && (inc == tgt)) return '0;
    return inc;
  endfunction

  // true when the next tick lands on the target
  function automatic logic lands_on(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] tgt
  );
    logic [CNT_W-1:0] inc;
    inc = cur + 1'b1;
    return inc == tgt;
  endfunction

  // true when the next tick wraps
  function automatic logic wraps(input logic [CNT_W-1:0] cur);
    return &cur;
  endfunction

endpackage

// File: rtl/tmr16_tick.sv
module tmr16_tick
  import tmr16_pkg::*;
#(
  parameter int PRESCALE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic stop,
  input  logic slow_sel,
  input  logic line_sel,
  input  logic ext_line,
  output logic tick
);

  logic pre_tick;
  logic line_q;
  logic line_rise;

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int DW = $clog2(PRESCALE);
      localparam logic [DW-1:0] LAST = DW'(PRESCALE - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n || restart) div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign pre_tick = (div_q == LAST);
    end else begin : g_nodiv
      assign pre_tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else line_q <= ext_line;
  end
  assign line_rise = ext_line & ~line_q;

  always_comb begin
    if (stop) tick = 1'b0;
    else if (!slow_sel) tick = 1'b1;
    else if (line_sel) tick = line_rise;
    else tick = pre_tick;
  end

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld_zero,
  input  logic             ld_val,
  input  logic [CNT_W-1:0] ld_data,
  input  logic [CNT_W-1:0] target,
  input  logic             zero_at_tgt,
  output logic [CNT_W-1:0] count,
  output logic             tgt_evt,
  output logic             ovf_evt
);

  logic step;

  assign step    = tick && !ld_zero && !ld_val;
  assign tgt_evt = step && lands_on(count, target);
  assign ovf_evt = step && wraps(count);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (ld_zero) count <= '0;
    else if (ld_val) count <= ld_data;
    else if (step) count <= next_on_tick(count, target, zero_at_tgt);
  end

endmodule

// File: rtl/tmr16_irq.sv
module tmr16_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic tgt_evt,
  input  logic ovf_evt,
  input  logic en_tgt,
  input  logic en_ovf,
  input  logic rep,
  output logic irq_pulse
);

  logic fired_q;
  logic want;
  logic fire;

  assign want = (tgt_evt && en_tgt) || (ovf_evt && en_ovf);
  assign fire = !rearm && want && (rep || !fired_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fired_q   <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= fire;
      if (rearm) fired_q <= 1'b0;
      else if (fire) fired_q <= 1'b1;
    end
  end

endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan
  import tmr16_pkg::*;
#(
  parameter int PRESCALE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        ext_line,
  output logic        irq_pulse
);

  logic [CFG_W-1:0] mode_cfg;
  logic             any_evt;
  logic             hit_tgt;
  logic             hit_ovf;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] count;
  logic             tick;
  logic             tgt_evt;
  logic             ovf_evt;
  logic             mode_wr;
  logic             cnt_wr;
  logic             tgt_wr;
  logic             mode_rd;
  logic [15:0]      mode_word;

  assign mode_wr = bus_wr && (bus_addr == SEL_MODE);
  assign cnt_wr  = bus_wr && (bus_addr == SEL_COUNT);
  assign tgt_wr  = bus_wr && (bus_addr == SEL_TARGET);
  assign mode_rd = bus_rd && (bus_addr == SEL_MODE) && !mode_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_cfg <= '0;
    else if (mode_wr) mode_cfg <= bus_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) target <= '0;
    else if (tgt_wr) target <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr) begin
      any_evt <= 1'b0;
      hit_tgt <= 1'b0;
      hit_ovf <= 1'b0;
    end else begin
      any_evt <= any_evt | tgt_evt | ovf_evt;
      hit_tgt <= (hit_tgt & ~mode_rd) | tgt_evt;
      hit_ovf <= (hit_ovf & ~mode_rd) | ovf_evt;
    end
  end

  assign mode_word = {3'b000, hit_ovf, hit_tgt, any_evt, mode_cfg};

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      SEL_COUNT:  bus_rdata = count;
      SEL_MODE:   bus_rdata = mode_word;
      SEL_TARGET: bus_rdata = target;
      default:    bus_rdata = '0;
    endcase
  end

  tmr16_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (mode_wr),
    .stop     (mode_cfg[MB_STOP]),
    .slow_sel (mode_cfg[MB_SLOW]),
    .line_sel (mode_cfg[MB_LINE]),
    .ext_line (ext_line),
    .tick     (tick)
  );

  tmr16_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .ld_zero     (mode_wr),
    .ld_val      (cnt_wr),
    .ld_data     (bus_wdata),
    .target      (target),
    .zero_at_tgt (mode_cfg[MB_ZERO_TGT]),
    .count       (count),
    .tgt_evt     (tgt_evt),
    .ovf_evt     (ovf_evt)
  );

  tmr16_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rearm     (mode_wr),
    .tgt_evt   (tgt_evt),
    .ovf_evt   (ovf_evt),
    .en_tgt    (mode_cfg[MB_IRQ_TGT]),
    .en_ovf    (mode_cfg[MB_IRQ_OVF]),
    .rep       (mode_cfg[MB_IRQ_REP]),
    .irq_pulse (irq_pulse)
  );

endmodule

// File: rtl/tmr16_chan_chk.sv
module tmr16_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_rdata,
  input logic [15:0] count,
  input logic        m_stop,
  input logic        m_zero,
  input logic        m_en_tgt,
  input logic        m_en_ovf,
  input logic        m_rep,
  input logic        hit_tgt,
  input logic        tgt_evt,
  input logic        ovf_evt,
  input logic        mode_wr,
  input logic        irq_pulse
);

  logic chk_fired;
  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr) chk_fired <= 1'b0;
    else if (irq_pulse) chk_fired <= 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) && !$past(bus_wr) |-> (count == $past(count) + 16'd1) || (count == 16'd0)); // R1

  AST_TGT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_evt && m_zero |=> count == 16'd0); // R2

  AST_TGT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_evt |=> hit_tgt); // R3

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past((tgt_evt && m_en_tgt) || (ovf_evt && m_en_ovf))); // R4

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse && !m_rep |-> !chk_fired); // R5

  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (count == 16'd0) && !irq_pulse); // R6

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata[15:13] == 3'b000)); // R6

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_stop && !bus_wr |=> $stable(count)); // R7

endmodule

bind tmr16_chan tmr16_chan_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .count     (count),
  .m_stop    (mode_cfg[0]),
  .m_zero    (mode_cfg[3]),
  .m_en_tgt  (mode_cfg[4]),
  .m_en_ovf  (mode_cfg[5]),
  .m_rep     (mode_cfg[6]),
  .hit_tgt   (hit_tgt),
  .tgt_evt   (tgt_evt),
  .ovf_evt   (ovf_evt),
  .mode_wr   (mode_wr),
  .irq_pulse (irq_pulse)
);

// File: tb/test_tmr16_chan.sv
module test_tmr16_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        ext_line = 1'b0;
  logic        irq_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr16_chan #(.PRESCALE(8)) i_tmr16_chan (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_line  (ext_line),
    .irq_pulse (irq_pulse)
  );

  // columns: mode, target, load, idle ticks, count after idle, mode word one tick later
  localparam logic [15:0] VEC [0:7][0:5] = '{
    '{16'h0000, 16'h0100, 16'h0000, 16'd5,  16'h0005, 16'h0000},
    '{16'h0008, 16'h0010, 16'h000C, 16'd3,  16'h000F, 16'h0C08},
    '{16'h0000, 16'h0010, 16'h000E, 16'd4,  16'h0012, 16'h0C00},
    '{16'h0000, 16'h0100, 16'hFFFE, 16'd1,  16'hFFFF, 16'h1400},
    '{16'h0008, 16'h0000, 16'hFFFD, 16'd2,  16'hFFFF, 16'h1C08},
    '{16'h0001, 16'h0005, 16'h0003, 16'd10, 16'h0003, 16'h0001},
    '{16'h0008, 16'h0003, 16'h0000, 16'd7,  16'h0001, 16'h0C08},
    '{16'hE286, 16'h1000, 16'h0010, 16'd2,  16'h0012, 16'h0286}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic watch_irq(input int n, output int pulses, output int longest);
    int run;
    pulses = 0; longest = 0; run = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_pulse) begin
        run++;
        if (run == 1) pulses++;
        if (run > longest) longest = run;
      end else run = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int p, lng;

    // R10: reset state
    repeat (3) @(negedge clk);
    bus_addr = 2'd0; #1 check("R10 count", bus_rdata, 16'h0000);
    bus_addr = 2'd1; #1 check("R10 mode", bus_rdata, 16'h0000);
    bus_addr = 2'd2; #1 check("R10 target", bus_rdata, 16'h0000);
    check("R10 irq", {15'd0, irq_pulse}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R1 R2 R3 R6 R7
    for (int k = 0; k < 8; k++) begin
      wr(2'd2, VEC[k][1]);
      wr(2'd1, VEC[k][0]);
      wr(2'd0, VEC[k][2]);
      idle(int'(VEC[k][3]));
      rd(2'd0, v);
      check($sformatf("R1 R2 R7 vector %0d count", k), v, VEC[k][4]);
      rd(2'd1, v);
      check($sformatf("R3 R6 vector %0d mode", k), v, VEC[k][5]);
    end

    // R5: one-shot, re-arm by mode write, then repeat
    wr(2'd2, 16'h0004);
    wr(2'd1, 16'h0018);
    watch_irq(20, p, lng);
    check("R5 one-shot pulses", 16'(p), 16'd1);
    wr(2'd1, 16'h0018);
    watch_irq(20, p, lng);
    check("R5 re-armed pulses", 16'(p), 16'd1);
    wr(2'd1, 16'h0058);
    watch_irq(20, p, lng);
    check("R5 repeat pulses", 16'(p), 16'd5);
    check("R4 pulse width", 16'(lng), 16'd1);

    // R4: overflow interrupt
    wr(2'd2, 16'h8000);
    wr(2'd1, 16'h0020);
    wr(2'd0, 16'hFFFD);
    watch_irq(10, p, lng);
    check("R4 overflow pulses", 16'(p), 16'd1);
    rd(2'd1, v);
    check("R3 overflow flags", v, 16'h1420);

    // R4 R3: target and overflow together
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0038);
    wr(2'd0, 16'hFFFE);
    watch_irq(5, p, lng);
    check("R4 coincident pulses", 16'(p), 16'd1);
    rd(2'd1, v);
    check("R3 coincident flags", v, 16'h1C38);
    rd(2'd1, v);
    check("R3 cleared by read", v, 16'h0438);

    // R8: prescaled tick
    wr(2'd1, 16'h0100);
    idle(24);
    rd(2'd0, v);
    check("R8 prescaler count", v, 16'h0003);

    // R8: line strobe tick
    wr(2'd1, 16'h0300);
    for (int e = 0; e < 3; e++) begin
      ext_line = 1'b1; idle(2);
      ext_line = 1'b0; idle(2);
    end
    rd(2'd0, v);
    check("R8 line edges", v, 16'h0003);

    // R9 R7: loads, target write, stop
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h2345);
    rd(2'd0, v);
    check("R9 count load", v, 16'h2345);
    wr(2'd2, 16'h0020);
    idle(5);
    rd(2'd0, v);
    check("R7 stopped count", v, 16'h2345);
    rd(2'd2, v);
    check("R9 target readback", v, 16'h0020);
    rd(2'd3, v);
    check("R9 unused address", v, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule